// File: doc/BRIEF.md
# Segmented Address Generator

This block turns a pair of 16-bit values, a segment base and an offset, into a 20-bit physical byte address for a 1 MiB space. It holds four segment registers (code, data, stack and extra). A request names one of them and supplies an offset. The block shifts the chosen base left by four bits, so the base always starts on a 16-byte boundary, and adds the offset. Because the base is a paragraph number and not a high-order address field, segments may overlap, and different base/offset pairs can reach the same byte.

Software or a sequencer loads the registers through a simple write port. Address requests arrive on a second port. Each accepted request produces a one-cycle pulse on the output valid flag one clock later, carrying the address. The block never applies back-pressure: it accepts a request on every cycle. The consumer must take each result in the cycle in which it appears, because nothing is held for it.

Top module: `seg_addr_gen`

## Requirements
- R1: The output address equals (selected segment value × 16 + offset), computed on 20 bits.
- R2: `req_seg` selects the register used for a request: 0 = code, 1 = data, 2 = stack, 3 = extra. Each register holds its own value independently of the others.
- R3: A carry out of bit 19 is dropped, so the address wraps modulo 2^20. For example, base 0xFFFF with offset 0x0010 gives 0x00000.
- R4: Pairs (s, o) and (s−1, o+16) give the same address.
- R5: When a register write and a request that reads the same register occur in the same cycle, the request uses the old value. The new value applies from the next cycle.
- R6: `addr_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R7: Reset (`rst_n` low, asynchronous) clears all four segment registers to 0 and drives `addr_valid` low.
- R8: With `wr_en` low, the values on `wr_idx` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the segment register chosen by `wr_idx` |
| wr_idx | input | 2 | Register to load: 0 code, 1 data, 2 stack, 3 extra |
| wr_data | input | 16 | New segment value (paragraph number) |
| req_valid | input | 1 | Address request present this cycle |
| req_seg | input | 2 | Segment register used by the request |
| req_off | input | 16 | Byte offset within the segment |
| addr_valid | output | 1 | Registered result flag, one cycle after a request |
| addr_out | output | 20 | Registered physical byte address |

## Verification
The assertions check the following on every cycle: the one-cycle valid pipeline in both directions, the result address against the base that was read in the previous cycle, and each register loading only when its own index is written and holding its value otherwise. Arithmetic cases cannot be shown by cycle-level properties alone: wrap-around past 1 MiB, aliasing between overlapping segments, and the old-value ordering when a write and a read of the same register occur together. The bench's scenarios cover these, along with the cleared contents after reset and an ignored write with the enable low.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_CNT   = 4;
  localparam int SEG_IDX_W = $clog2(SEG_CNT);

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;
endpackage

// File: rtl/seg_file.sv
module seg_file #(
  parameter int SEG_W = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         wr_en,
  input  logic [seg_addr_pkg::SEG_IDX_W-1:0]           wr_idx,
  input  logic [SEG_W-1:0]                             wr_data,
  input  logic [seg_addr_pkg::SEG_IDX_W-1:0]           rd_idx,
  output logic [SEG_W-1:0]                             rd_base,
  output logic [seg_addr_pkg::SEG_CNT*SEG_W-1:0]       bank_flat
);
  import seg_addr_pkg::*;

  logic [SEG_W-1:0] slot_q [SEG_CNT];

  // one register per segment; the read below sees the pre-write value
  for (genvar g = 0; g < SEG_CNT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_idx == SEG_IDX_W'(g)))
        slot_q[g] <= wr_data;
    end
    assign bank_flat[g*SEG_W +: SEG_W] = slot_q[g];
  end

  assign rd_base = slot_q[rd_idx];
endmodule

// File: rtl/addr_fold.sv
module addr_fold #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] base,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] base_sh;
  logic [PA_W-1:0] off_ext;

  // paragraph base moved up by SHIFT; sum is kept at PA_W bits so the top carry falls away
  assign base_sh = PA_W'({base, {SHIFT{1'b0}}});
  assign off_ext = PA_W'(off);
  assign pa      = base_sh + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [seg_addr_pkg::SEG_IDX_W-1:0]  wr_idx,
  input  logic [SEG_W-1:0]                    wr_data,
  input  logic                                req_valid,
  input  logic [seg_addr_pkg::SEG_IDX_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]                    req_off,
  output logic                                addr_valid,
  output logic [SEG_W+SHIFT-1:0]              addr_out
);
  import seg_addr_pkg::*;

  localparam int PA_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]         sel_base;
  logic [SEG_CNT*SEG_W-1:0] bank_flat;
  logic [PA_W-1:0]          pa_next;

  seg_file #(.SEG_W(SEG_W)) u_segs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (req_seg),
    .rd_base   (sel_base),
    .bank_flat (bank_flat)
  );

  addr_fold #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT),
    .PA_W  (PA_W)
  ) u_fold (
    .base (sel_base),
    .off  (req_off),
    .pa   (pa_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid)
        addr_out <= pa_next;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    wr_en,
  input logic [seg_addr_pkg::SEG_IDX_W-1:0]      wr_idx,
  input logic [SEG_W-1:0]                        wr_data,
  input logic                                    req_valid,
  input logic [OFF_W-1:0]                        req_off,
  input logic [SEG_W-1:0]                        sel_base,
  input logic [seg_addr_pkg::SEG_CNT*SEG_W-1:0]  bank_flat,
  input logic                                    addr_valid,
  input logic [SEG_W+SHIFT-1:0]                  addr_out
);
  import seg_addr_pkg::*;
  localparam int PA_W = SEG_W + SHIFT;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);

  // R1
  addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_out == (PA_W'({$past(sel_base), {SHIFT{1'b0}}}) + PA_W'($past(req_off))));

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_reg_chk
    // R5
    seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == SEG_IDX_W'(g)) |=> bank_flat[g*SEG_W +: SEG_W] == $past(wr_data));

    // R8
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == SEG_IDX_W'(g)) |=> $stable(bank_flat[g*SEG_W +: SEG_W]));
  end
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .SHIFT (SHIFT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .req_valid  (req_valid),
  .req_off    (req_off),
  .sel_base   (sel_base),
  .bank_flat  (bank_flat),
  .addr_valid (addr_valid),
  .addr_out   (addr_out)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  import seg_addr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic        addr_valid;
  logic [19:0] addr_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          v;
    logic [19:0] a;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [4];

  always #2.5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .req_valid (req_valid), .req_seg (req_seg), .req_off (req_off),
    .addr_valid (addr_valid), .addr_out (addr_out)
  );

  function automatic logic [19:0] calc(logic [15:0] s, logic [15:0] o);
    return 20'({s, 4'h0}) + 20'(o);
  endfunction

  // driver: one cycle of stimulus, expectation pushed from the shadow model
  task automatic step(bit v, logic [1:0] s, logic [15:0] o,
                      bit we, logic [1:0] wi, logic [15:0] wd, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_seg = s; req_off = o;
    wr_en = we; wr_idx = wi; wr_data = wd;
    e.v = v; e.a = calc(model[s], o); e.tag = tag;
    sb_q.push_back(e);
    if (we) model[wi] = wd;
  endtask

  task automatic req(logic [1:0] s, logic [15:0] o, string tag);
    step(1'b1, s, o, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic load(logic [1:0] i, logic [15:0] d, string tag);
    step(1'b0, 2'd0, 16'h0, 1'b1, i, d, tag);
  endtask

  // monitor: compares each produced cycle with the queued expectation
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        e = sb_q.pop_front();
        checks++;
        if (addr_valid !== e.v) begin
          errors++;
          $display("FAIL %s valid got %0b exp %0b", e.tag, addr_valid, e.v);
        end else if (e.v && addr_out !== e.a) begin
          errors++;
          $display("FAIL %s addr got %05h exp %05h", e.tag, addr_out, e.a);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R7: output valid low while reset held, even with a request present
    checks++;
    if (addr_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset valid got %0b exp 0", addr_valid);
    end
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R7: all registers cleared, address equals the offset
    req(SEG_CODE,  16'h1234, "R7 code cleared");
    req(SEG_DATA,  16'hBEEF, "R7 data cleared");
    req(SEG_STACK, 16'h0001, "R7 stack cleared");
    req(SEG_EXTRA, 16'hFFFF, "R7 extra cleared");

    // R2: load distinct values
    load(SEG_CODE,  16'h1000, "R6 idle during load");
    load(SEG_DATA,  16'h2345, "R6 idle during load");
    load(SEG_STACK, 16'hFFFF, "R6 idle during load");
    load(SEG_EXTRA, 16'h0800, "R6 idle during load");

    // R1/R2: each register selected, back-to-back requests
    req(SEG_CODE,  16'h0000, "R2 code base");
    req(SEG_DATA,  16'h00AB, "R1 data sum");
    req(SEG_EXTRA, 16'h8001, "R2 extra select");
    req(SEG_CODE,  16'hF00F, "R1 code sum");

    // R3: wrap past 1 MiB
    req(SEG_STACK, 16'h0010, "R3 wrap to zero");
    req(SEG_STACK, 16'hFFFF, "R3 wrap high");
    req(SEG_STACK, 16'h000F, "R3 no wrap edge");

    // R4: aliasing (s,o) vs (s-1,o+16)
    load(SEG_EXTRA, 16'h2344, "R6 idle");
    req(SEG_DATA,  16'h0020, "R4 alias first");
    req(SEG_EXTRA, 16'h0030, "R4 alias second");

    // R5: write and request on the same register in one cycle
    step(1'b1, SEG_CODE, 16'h0001, 1'b1, SEG_CODE, 16'h4000, "R5 old value");
    req(SEG_CODE, 16'h0001, "R5 new value");

    // R8: write bus active with enable low
    step(1'b0, 2'd0, 16'h0, 1'b0, SEG_DATA, 16'hAAAA, "R8 idle");
    req(SEG_DATA, 16'h0000, "R8 data unchanged");

    // R6: idle gaps
    step(1'b0, SEG_DATA, 16'h5555, 1'b0, 2'd0, 16'h0, "R6 gap");
    req(SEG_EXTRA, 16'h0004, "R6 after gap");
    step(1'b0, SEG_DATA, 16'h5555, 1'b0, 2'd0, 16'h0, "R6 final idle");

    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule